// File: doc/BRIEF.md
# Continuous Enabled-Channel Scan Sequencer

This block drives a multi-channel analog-to-digital converter through a repeating scan. Software supplies a channel-enable mask and holds a start bit. The sequencer then visits only the enabled channels, lowest number first. For each channel it presents the channel-select code and raises a sample strobe for a fixed number of cycles. It then waits for the converter's done pulse and stores the returned word in that channel's own result slot. After the highest enabled channel, it wraps straight back to the lowest enabled one. It keeps scanning until software drops the start bit.

Each result slot has a fresh-data flag and an overrun flag. A read strobe naming a channel clears both flags for that channel. When the result of the highest enabled channel lands, a one-cycle pass-complete pulse marks the end of a pass.

The controller has three states. ST_IDLE moves to ST_SAMPLE when start is set and the mask is non-zero (transition *launch*). ST_SAMPLE moves to ST_CONVERT after the strobe window (transition *hold_done*). ST_CONVERT has two exits on the done pulse: it moves back to ST_SAMPLE for the next higher enabled channel (transition *advance*), or for the lowest one after the top channel (transition *wrap*). ST_SAMPLE and ST_CONVERT both fall to ST_IDLE whenever start is low (transition *abort*). ST_CONVERT also falls to ST_IDLE if the mask has become empty when a pass ends.

Top module: `scan_seq_top`

## Requirements
- R1: With start held, the channels presented on `ch_sel` at each sample window are exactly the enabled channels (bit n of `ch_en` enables channel n), in ascending order; disabled channels are never selected.
- R2: After the highest enabled channel's result is stored, the next sample window selects the lowest enabled channel, with no idle cycle in between, for as long as start stays high.
- R3: In the cycle after start is seen low, `sample` is low and no further sample window begins until start is set again.
- R4: `sample` stays high for exactly SAMPLE_CYC consecutive cycles per channel, and `ch_sel` holds steady throughout that window.
- R5: A `conv_done` pulse in the convert phase stores `conv_data` into the selected channel's slot, bits [n*DATA_W +: DATA_W] of `result`, and sets `valid[n]`, both visible on the next cycle.
- R6: With start high and an all-zero mask, no sample window occurs and no slot changes.
- R7: When start is cleared before `conv_done` arrives, the pending conversion is dropped: a later `conv_done` writes nothing.
- R8: A `conv_done` pulse that arrives while `sample` is high is ignored.
- R9: `pass_done` is high for exactly one cycle, the cycle after the highest enabled channel's result is written, and at no other time.
- R10: A one-cycle `rd_en` with channel number `rd_ch` clears `valid` and `overrun` for that channel on the next cycle.
- R11: Writing a result into a slot whose `valid` bit is still set raises that channel's `overrun` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Scan run bit held by software |
| ch_en | input | NUM_CH | Channel enable mask, bit n = channel n |
| conv_done | input | 1 | Conversion finished pulse from the converter |
| conv_data | input | DATA_W | Conversion result word |
| rd_en | input | 1 | Read strobe; clears flags of `rd_ch` |
| rd_ch | input | SEL_W | Channel being read |
| ch_sel | output | SEL_W | Channel select to the converter |
| sample | output | 1 | Sample-phase strobe |
| result | output | NUM_CH*DATA_W | Per-channel result slots, channel n at [n*DATA_W +: DATA_W] |
| valid | output | NUM_CH | Fresh-result flag per channel |
| overrun | output | NUM_CH | Unread-result overwrite flag per channel |
| pass_done | output | 1 | One-cycle end-of-pass pulse |

## Verification
A corrupted channel pointer shows on `ch_sel` at the very next sample window, as a skipped, repeated or disabled channel. It also shows one conversion later as a result landing in the wrong slot. A stuck or miscounted sample counter changes the width of the `sample` pulse within the first channel. A wrong ST_CONVERT exit shows either as a missing `pass_done` at the end of a pass, or as a write after start falls, visible on `valid` one cycle after the stray done pulse.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2
    } scan_state_e;
endpackage

// File: rtl/scan_pick.sv
`timescale 1ns/1ps
// Finds the next enabled channel above the current one and the lowest enabled channel.
module scan_pick #(
    parameter int NUM_CH = 8,
    parameter int SEL_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [SEL_W-1:0]  cur,
    output logic              above_ok,
    output logic [SEL_W-1:0]  above_ch,
    output logic              low_ok,
    output logic [SEL_W-1:0]  low_ch
);
    always_comb begin
        above_ok = 1'b0;
        above_ch = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i] && (i > int'(cur))) begin
                above_ok = 1'b1;
                above_ch = SEL_W'(i);
            end
        end
    end

    always_comb begin
        low_ok = |mask;
        low_ch = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                low_ch = SEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/scan_fsm.sv
`timescale 1ns/1ps
module scan_fsm
    import scan_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int SAMPLE_CYC = 4,
    parameter int SEL_W      = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic              conv_done,
    output logic [SEL_W-1:0]  ch_sel,
    output logic              sample,
    output logic              wr_en,
    output logic              pass_done
);
    localparam int CNT_W = (SAMPLE_CYC < 2) ? 1 : $clog2(SAMPLE_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_CYC - 1);

    scan_state_e      state_q, state_d;
    logic [SEL_W-1:0] cur_q, cur_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pass_q, pass_d;
    logic             above_ok, low_ok;
    logic [SEL_W-1:0] above_ch, low_ch;

    scan_pick #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) i_pick (
        .mask     (ch_en),
        .cur      (cur_q),
        .above_ok (above_ok),
        .above_ch (above_ch),
        .low_ok   (low_ok),
        .low_ch   (low_ch)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            cnt_q   <= '0;
            pass_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            cnt_q   <= cnt_d;
            pass_q  <= pass_d;
        end
    end

    // Next state and transition outputs
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        cnt_d   = cnt_q;
        pass_d  = 1'b0;
        wr_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && low_ok) begin          // launch
                    state_d = ST_SAMPLE;
                    cur_d   = low_ch;
                    cnt_d   = '0;
                end
            end
            ST_SAMPLE: begin
                if (!start) begin                   // abort
                    state_d = ST_IDLE;
                end else if (cnt_q == CNT_LAST) begin // hold_done
                    state_d = ST_CONVERT;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_CONVERT: begin
                if (!start) begin                   // abort
                    state_d = ST_IDLE;
                end else if (conv_done) begin
                    wr_en = 1'b1;
                    cnt_d = '0;
                    if (above_ok) begin             // advance
                        state_d = ST_SAMPLE;
                        cur_d   = above_ch;
                    end else begin                  // wrap
                        pass_d = 1'b1;
                        if (low_ok) begin
                            state_d = ST_SAMPLE;
                            cur_d   = low_ch;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign ch_sel    = cur_q;
    assign sample    = (state_q == ST_SAMPLE);
    assign pass_done = pass_q;

    p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !sample);
    p_sel_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && $past(sample)) |-> $stable(ch_sel));
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < SAMPLE_CYC);
    p_empty_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ch_en == '0) |=> !sample);
    p_pass_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);
    p_no_write_in_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> !wr_en);
endmodule

// File: rtl/scan_bank.sv
`timescale 1ns/1ps
module scan_bank #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 12,
    parameter int SEL_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_ch,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_en,
    input  logic [SEL_W-1:0]         rd_ch,
    output logic [NUM_CH*DATA_W-1:0] data_flat,
    output logic [NUM_CH-1:0]        valid,
    output logic [NUM_CH-1:0]        overrun
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        logic hit_wr, hit_rd;
        assign hit_wr = wr_en && (wr_ch == SEL_W'(g));
        assign hit_rd = rd_en && (rd_ch == SEL_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_flat[g*DATA_W +: DATA_W] <= '0;
                valid[g]   <= 1'b0;
                overrun[g] <= 1'b0;
            end else if (hit_wr) begin
                data_flat[g*DATA_W +: DATA_W] <= wr_data;
                valid[g] <= 1'b1;
                if (valid[g] && !hit_rd) begin
                    overrun[g] <= 1'b1;
                end
            end else if (hit_rd) begin
                valid[g]   <= 1'b0;
                overrun[g] <= 1'b0;
            end
        end
    end

    p_valid_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid[$past(wr_ch)]);
    p_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && valid[wr_ch] && !(rd_en && rd_ch == wr_ch)) |=> overrun[$past(wr_ch)]);
    p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(wr_en && wr_ch == rd_ch)) |=> !valid[$past(rd_ch)]);
endmodule

// File: rtl/scan_seq_top.sv
`timescale 1ns/1ps
module scan_seq_top #(
    parameter int NUM_CH     = 8,
    parameter int DATA_W     = 12,
    parameter int SAMPLE_CYC = 4,
    parameter int SEL_W      = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [NUM_CH-1:0]        ch_en,
    input  logic                     conv_done,
    input  logic [DATA_W-1:0]        conv_data,
    input  logic                     rd_en,
    input  logic [SEL_W-1:0]         rd_ch,
    output logic [SEL_W-1:0]         ch_sel,
    output logic                     sample,
    output logic [NUM_CH*DATA_W-1:0] result,
    output logic [NUM_CH-1:0]        valid,
    output logic [NUM_CH-1:0]        overrun,
    output logic                     pass_done
);
    logic wr_en;

    scan_fsm #(.NUM_CH(NUM_CH), .SAMPLE_CYC(SAMPLE_CYC), .SEL_W(SEL_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ch_en     (ch_en),
        .conv_done (conv_done),
        .ch_sel    (ch_sel),
        .sample    (sample),
        .wr_en     (wr_en),
        .pass_done (pass_done)
    );

    scan_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .SEL_W(SEL_W)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_ch     (ch_sel),
        .wr_data   (conv_data),
        .rd_en     (rd_en),
        .rd_ch     (rd_ch),
        .data_flat (result),
        .valid     (valid),
        .overrun   (overrun)
    );

    p_write_needs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && conv_done) |=> $stable(valid) || (rd_en === 1'b1) || $past(rd_en));
endmodule

// File: tb/test_scan_seq_top.sv
`timescale 1ns/1ps
module test_scan_seq_top;
    localparam int NUM_CH = 8;
    localparam int DATA_W = 12;
    localparam int SAMPLE_CYC = 4;
    localparam int SEL_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NUM_CH-1:0] ch_en = '0;
    logic conv_done = 1'b0;
    logic [DATA_W-1:0] conv_data = '0;
    logic rd_en = 1'b0;
    logic [SEL_W-1:0] rd_ch = '0;
    logic [SEL_W-1:0] ch_sel;
    logic sample;
    logic [NUM_CH*DATA_W-1:0] result;
    logic [NUM_CH-1:0] valid, overrun;
    logic pass_done;

    int n_chk = 0;
    int n_fail = 0;
    bit exp_valid [NUM_CH];
    bit exp_ovr [NUM_CH];
    logic [DATA_W-1:0] exp_data [NUM_CH];

    always #4 clk = ~clk;

    scan_seq_top #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .SAMPLE_CYC(SAMPLE_CYC)) i_scan_seq_top (
        .clk(clk), .rst_n(rst_n), .start(start), .ch_en(ch_en),
        .conv_done(conv_done), .conv_data(conv_data), .rd_en(rd_en), .rd_ch(rd_ch),
        .ch_sel(ch_sel), .sample(sample), .result(result), .valid(valid),
        .overrun(overrun), .pass_done(pass_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int lowest(input logic [NUM_CH-1:0] m);
        for (int i = 0; i < NUM_CH; i++) if (m[i]) return i;
        return -1;
    endfunction

    function automatic int above(input logic [NUM_CH-1:0] m, input int c);
        for (int i = c + 1; i < NUM_CH; i++) if (m[i]) return i;
        return -1;
    endfunction

    // One conversion as the converter model sees it
    task automatic convert_one(input int exp_ch, input bit exp_pass, input int dly,
                               input logic [DATA_W-1:0] val);
        int w = 0;
        int guard = 0;
        int ch;
        bit moved = 0;
        while (!sample && guard < 50) begin @(negedge clk); guard++; end
        ch = int'(ch_sel);
        while (sample) begin
            if (int'(ch_sel) != ch) moved = 1;
            w++;
            @(negedge clk);
        end
        chk("R1 channel order", ch, exp_ch);
        chk("R4 sample width", w, SAMPLE_CYC);
        chk("R4 select steady", moved, 0);
        repeat (dly) @(negedge clk);
        conv_done = 1'b1;
        conv_data = val;
        @(negedge clk);
        conv_done = 1'b0;
        if (exp_valid[ch]) exp_ovr[ch] = 1'b1;
        exp_valid[ch] = 1'b1;
        exp_data[ch] = val;
        chk("R5 result data", result[ch*DATA_W +: DATA_W], val);
        chk("R5 valid set", valid[ch], 1);
        chk("R11 overrun", overrun[ch], exp_ovr[ch]);
        chk("R9 pass pulse", pass_done, exp_pass);
        if (exp_pass) chk("R2 wrap no gap", sample, 1);
    endtask

    task automatic run_scan(input logic [NUM_CH-1:0] m, input int passes);
        int c;
        ch_en = m;
        start = 1'b1;
        for (int p = 0; p < passes; p++) begin
            c = lowest(m);
            while (c >= 0) begin
                int n = above(m, c);
                convert_one(c, n < 0, $urandom_range(0, 3), DATA_W'($urandom));
                c = n;
            end
        end
        start = 1'b0;
        @(negedge clk);
        chk("R3 stop", sample, 0);
        repeat (3) @(negedge clk);
        chk("R3 stays idle", sample, 0);
    endtask

    task automatic read_ch(input int c);
        rd_en = 1'b1;
        rd_ch = SEL_W'(c);
        @(negedge clk);
        rd_en = 1'b0;
        exp_valid[c] = 1'b0;
        exp_ovr[c] = 1'b0;
        chk("R10 valid cleared", valid[c], 0);
        chk("R10 overrun cleared", overrun[c], 0);
    endtask

    task automatic check_slots(input string req);
        for (int i = 0; i < NUM_CH; i++) begin
            chk(req, valid[i], exp_valid[i]);
            chk(req, result[i*DATA_W +: DATA_W], exp_data[i]);
        end
    endtask

    initial begin
        #1200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < NUM_CH; i++) begin
            exp_valid[i] = 0; exp_ovr[i] = 0; exp_data[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset sample", sample, 0);
        chk("reset valid", valid, 0);
        chk("reset overrun", overrun, 0);
        chk("reset pass", pass_done, 0);

        // R1 R2 R11: channels 0,2,3,7 over two passes
        run_scan(8'h8D, 2);
        for (int i = 0; i < NUM_CH; i++) read_ch(i);

        // R2 R9: single channel wraps onto itself
        run_scan(8'h80, 2);
        read_ch(7);

        // R6: empty mask
        ch_en = '0;
        start = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk("R6 empty mask no sample", sample, 0);
        end
        check_slots("R6 slots untouched");
        start = 1'b0;
        @(negedge clk);

        // R7: abandon during convert phase
        ch_en = 8'h10;
        start = 1'b1;
        while (!sample) @(negedge clk);
        while (sample) @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        conv_done = 1'b1;
        conv_data = 12'hABC;
        @(negedge clk);
        conv_done = 1'b0;
        @(negedge clk);
        chk("R7 abandoned not written", valid[4], 0);
        chk("R3 idle after abort", sample, 0);
        check_slots("R7 slots untouched");

        // R8: done pulse during sample window
        ch_en = 8'h02;
        start = 1'b1;
        while (!sample) @(negedge clk);
        conv_done = 1'b1;
        conv_data = 12'h321;
        @(negedge clk);
        conv_done = 1'b0;
        @(negedge clk);
        chk("R8 done in sample ignored", valid[1], 0);
        start = 1'b0;
        @(negedge clk);
        check_slots("R8 slots untouched");

        // Random masks
        for (int t = 0; t < 8; t++) begin
            logic [NUM_CH-1:0] m;
            m = NUM_CH'($urandom);
            if (m == '0) m = 8'h41;
            run_scan(m, $urandom_range(1, 3));
            check_slots("R5 slot contents");
            for (int i = 0; i < NUM_CH; i++) if ($urandom_range(0, 1) == 1) read_ch(i);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule